// File: doc/BRIEF.md
# HDLC receive line status monitor

This block sits behind the receive bit recovery of a serial controller and watches the decoded bit stream. It reports two line conditions as they happen: whether HDLC flag octets (0x7E) are arriving, and whether the line has been sitting at logic one long enough to count as idle. A carrier indication produced elsewhere is registered and placed beside them. The three indicators are presented in a read-only 8-bit status word.

Bits advance only on clock cycles where the bit-valid strobe is high. While the flag indicator is low, every new bit slides an eight-bit window and the window is compared against the flag pattern. On a match the indicator sets at once. From then on the block collects the following eight bits as one aligned group. If that group is a flag, the indicator holds for another group. If it is not, the indicator drops and the per-bit search resumes with the next bit.

Top module: `hdlc_line_monitor`

## Requirements
- R1: The status word is 8 bits, with bit 0 as the MSB: bits 0 to 4 (status_o[7:3]) always read zero, bit 5 (status_o[2]) is the flag indicator, bit 6 (status_o[1]) is carrier sense and bit 7 (status_o[0]) is idle.
- R2: While rst_ni is low, every bit of status_o is zero.
- R3: While the flag indicator is clear, it sets on the clock edge that accepts a valid bit completing 0x7E in the last eight valid bits.
- R4: Once set, the flag indicator stays set for the next seven valid bits whatever their values.
- R5: On the eighth valid bit after a match, the indicator stays set for another group if those eight bits form 0x7E. Otherwise it clears on that edge and the per-bit search starts again from the next bit.
- R6: The idle indicator sets on the edge that accepts the 15th consecutive valid one.
- R7: The idle indicator clears on the edge that accepts a single valid zero.
- R8: The ones count saturates, so idle stays set through any run of ones longer than 15.
- R9: Flag and idle state does not change on cycles where bit_vld_i is low.
- R10: The carrier-sense status bit equals carrier_i delayed by one clock.
- R11: No flag is reported until at least eight valid bits have been received since reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bit_vld_i | input | 1 | Strobe: rx_bit_i carries a new decoded bit this cycle |
| rx_bit_i | input | 1 | Decoded receive bit |
| carrier_i | input | 1 | Carrier indication from the bit recovery logic |
| status_o | output | 8 | Status word {5'b0, flag, carrier, idle} |

## Verification
A wrong window or group count shows up on the flag bit. Either the indicator rises on a bit where no 0x7E has been completed, or it falls on the wrong valid bit of the aligned group, which is at most eight valid bits after the fault. A corrupted ones count shows up on the idle bit within fifteen valid bits, or at once on the next zero. A wrong carrier register differs from carrier_i's previous value on the very next clock. Because the bench compares the whole status word with a behavioural model on every clock, each of these is seen in the cycle where it first appears.

// File: rtl/hdlc_mon_pkg.sv
package hdlc_mon_pkg;
  localparam int unsigned STAT_W        = 8;
  localparam int unsigned STAT_IDLE_BIT = 0;
  localparam int unsigned STAT_CS_BIT   = 1;
  localparam int unsigned STAT_FLAG_BIT = 2;

  typedef enum logic {
    FLG_SEARCH = 1'b0,
    FLG_HOLD   = 1'b1
  } flag_state_e;
endpackage

// File: rtl/hdlc_shift_win.sv
module hdlc_shift_win #(
  parameter int unsigned WIN_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             bit_vld_i,
  input  logic             rx_bit_i,
  output logic [WIN_W-1:0] win_nxt_o,
  output logic             full_nxt_o
);
  localparam int unsigned FILL_W = $clog2(WIN_W + 1);
  localparam logic [FILL_W-1:0] FILL_MAX = FILL_W'(WIN_W);

  logic [WIN_W-1:0]  win_q;
  logic [FILL_W-1:0] fill_q;

  // Window as it will be after accepting the current bit.
  assign win_nxt_o  = {win_q[WIN_W-2:0], rx_bit_i};
  assign full_nxt_o = (fill_q >= FILL_MAX - FILL_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      win_q  <= '0;
      fill_q <= '0;
    end else if (bit_vld_i) begin
      win_q <= win_nxt_o;
      if (fill_q != FILL_MAX) fill_q <= fill_q + FILL_W'(1);
    end
  end
endmodule

// File: rtl/hdlc_flag_track.sv
module hdlc_flag_track
  import hdlc_mon_pkg::*;
#(
  parameter int unsigned      WIN_W   = 8,
  parameter logic [WIN_W-1:0] PATTERN = 8'h7E
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             bit_vld_i,
  input  logic [WIN_W-1:0] win_nxt_i,
  input  logic             full_nxt_i,
  output logic             flag_o
);
  localparam int unsigned GRP_W = $clog2(WIN_W);
  localparam logic [GRP_W-1:0] GRP_LAST = GRP_W'(WIN_W - 1);

  flag_state_e      state_q;
  logic [GRP_W-1:0] grp_cnt_q;
  logic             hit;

  assign hit = full_nxt_i && (win_nxt_i == PATTERN);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= FLG_SEARCH;
      grp_cnt_q <= '0;
    end else if (bit_vld_i) begin
      unique case (state_q)
        FLG_SEARCH: begin
          grp_cnt_q <= '0;
          if (hit) state_q <= FLG_HOLD;
        end
        FLG_HOLD: begin
          if (grp_cnt_q == GRP_LAST) begin
            // Aligned group complete: keep only on another flag.
            grp_cnt_q <= '0;
            if (!hit) state_q <= FLG_SEARCH;
          end else begin
            grp_cnt_q <= grp_cnt_q + GRP_W'(1);
          end
        end
        default: state_q <= FLG_SEARCH;
      endcase
    end
  end

  assign flag_o = (state_q == FLG_HOLD);
endmodule

// File: rtl/hdlc_idle_det.sv
module hdlc_idle_det #(
  parameter int unsigned IDLE_RUN = 15
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic bit_vld_i,
  input  logic rx_bit_i,
  output logic idle_o
);
  localparam int unsigned CNT_W = $clog2(IDLE_RUN + 1);
  localparam logic [CNT_W-1:0] CNT_SAT = CNT_W'(IDLE_RUN);

  logic [CNT_W-1:0] ones_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ones_q <= '0;
    end else if (bit_vld_i) begin
      if (!rx_bit_i)             ones_q <= '0;
      else if (ones_q != CNT_SAT) ones_q <= ones_q + CNT_W'(1);
    end
  end

  assign idle_o = (ones_q == CNT_SAT);
endmodule

// File: rtl/hdlc_line_monitor.sv
module hdlc_line_monitor
  import hdlc_mon_pkg::*;
#(
  parameter int unsigned WIN_W    = 8,
  parameter logic [7:0]  PATTERN  = 8'h7E,
  parameter int unsigned IDLE_RUN = 15
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bit_vld_i,
  input  logic              rx_bit_i,
  input  logic              carrier_i,
  output logic [STAT_W-1:0] status_o
);
  logic [WIN_W-1:0] win_nxt;
  logic             full_nxt;
  logic             flag;
  logic             idle;
  logic             carrier_q;

  hdlc_shift_win #(.WIN_W(WIN_W)) u_win (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .bit_vld_i  (bit_vld_i),
    .rx_bit_i   (rx_bit_i),
    .win_nxt_o  (win_nxt),
    .full_nxt_o (full_nxt)
  );

  hdlc_flag_track #(.WIN_W(WIN_W), .PATTERN(WIN_W'(PATTERN))) u_flag (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .bit_vld_i  (bit_vld_i),
    .win_nxt_i  (win_nxt),
    .full_nxt_i (full_nxt),
    .flag_o     (flag)
  );

  hdlc_idle_det #(.IDLE_RUN(IDLE_RUN)) u_idle (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .bit_vld_i (bit_vld_i),
    .rx_bit_i  (rx_bit_i),
    .idle_o    (idle)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) carrier_q <= 1'b0;
    else         carrier_q <= carrier_i;
  end

  always_comb begin
    status_o                = '0;
    status_o[STAT_FLAG_BIT] = flag;
    status_o[STAT_CS_BIT]   = carrier_q;
    status_o[STAT_IDLE_BIT] = idle;
  end
endmodule

// File: rtl/hdlc_line_monitor_chk.sv
module hdlc_line_monitor_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       bit_vld_i,
  input logic       rx_bit_i,
  input logic       carrier_i,
  input logic [7:0] status_o
);
  a_r1_reserved_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    status_o[7:3] == 5'b0);

  a_r10_carrier_follow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> status_o[1] == $past(carrier_i));

  a_r9_flag_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bit_vld_i |=> $stable(status_o[2]));

  a_r9_idle_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bit_vld_i |=> $stable(status_o[0]));

  a_r7_zero_clears_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bit_vld_i && !rx_bit_i |=> !status_o[0]);

  a_r6_idle_rise_on_one: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(status_o[0]) |-> $past(bit_vld_i && rx_bit_i));

  a_r8_idle_sticks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    status_o[0] && bit_vld_i && rx_bit_i |=> status_o[0]);

  a_r3_flag_rise_on_bit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(status_o[2]) |-> $past(bit_vld_i));

  a_r5_flag_fall_on_bit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(status_o[2]) |-> $past(bit_vld_i));
endmodule

bind hdlc_line_monitor hdlc_line_monitor_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .bit_vld_i (bit_vld_i),
  .rx_bit_i  (rx_bit_i),
  .carrier_i (carrier_i),
  .status_o  (status_o)
);

// File: tb/hdlc_line_monitor_bench.sv
`timescale 1ns/1ps
module hdlc_line_monitor_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       vld = 1'b0;
  logic       rx = 1'b1;
  logic       carrier = 1'b0;
  logic [7:0] status;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  hdlc_line_monitor u_hdlc_line_monitor (
    .clk_i     (clk),
    .rst_ni    (rst_n),
    .bit_vld_i (vld),
    .rx_bit_i  (rx),
    .carrier_i (carrier),
    .status_o  (status)
  );

  // Behavioural reference model
  bit [7:0] hist;
  int       seen;
  bit       m_flag;
  int       m_grp;
  int       m_ones;
  bit       m_car;

  always @(posedge clk) begin
    if (!rst_n) begin
      hist = 8'h00; seen = 0; m_flag = 0; m_grp = 0; m_ones = 0; m_car = 0;
    end else begin
      m_car = carrier;
      if (vld) begin
        hist = {hist[6:0], rx};
        seen++;
        if (!m_flag) begin
          if (seen >= 8 && hist == 8'h7E) begin m_flag = 1; m_grp = 0; end
        end else begin
          m_grp++;
          if (m_grp == 8) begin
            if (hist == 8'h7E) m_grp = 0;
            else m_flag = 0;
          end
        end
        m_ones = rx ? m_ones + 1 : 0;
      end
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      check(status[7:3] == 5'b0, "R1 reserved bits", status[7:3], 0);
      check(status[2] == m_flag, "R3/R5 flag model", status[2], m_flag);
      check(status[1] == m_car, "R10 carrier model", status[1], m_car);
      check(status[0] == (m_ones >= 15), "R6/R7 idle model", status[0], m_ones >= 15);
    end
  end

  task automatic send_bit(input bit b);
    vld = 1'b1; rx = b;
    @(negedge clk);
    vld = 1'b0;
  endtask

  task automatic send_byte(input bit [7:0] v);
    for (int i = 7; i >= 0; i--) send_bit(v[i]);
  endtask

  task automatic idle_cycles(input int n);
    for (int i = 0; i < n; i++) begin
      rx = ~rx;
      @(negedge clk);
    end
  endtask

  initial begin
    #(5ns * 100000);
    checks++; errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] snap;
    carrier = 1'b1; vld = 1'b1; rx = 1'b0;
    repeat (3) @(negedge clk);
    check(status == 8'h00, "R2 reset state", status, 0);
    vld = 1'b0; carrier = 1'b0;
    rst_n = 1'b1;
    @(negedge clk);

    // R11: seven bits that would complete 0x7E against a zeroed window
    for (int i = 0; i < 6; i++) send_bit(1'b1);
    send_bit(1'b0);
    check(status[2] == 1'b0, "R11 no flag before eight bits", status[2], 0);

    // R3: full flag
    send_byte(8'h7E);
    check(status[2] == 1'b1, "R3 flag sets on match", status[2], 1);
    // R4: held for seven more bits
    for (int i = 0; i < 7; i++) send_bit(1'b0);
    check(status[2] == 1'b1, "R4 flag held seven bits", status[2], 1);
    send_bit(1'b0);
    check(status[2] == 1'b0, "R5 flag clears on non-flag group", status[2], 0);

    // R5: repeated flags keep it set
    send_byte(8'h7E); send_byte(8'h7E); send_byte(8'h7E);
    check(status[2] == 1'b1, "R5 back-to-back flags hold", status[2], 1);
    // misaligned flag: aligned group 0000_0111 fails, then search finds it
    send_byte(8'h07);
    check(status[2] == 1'b0, "R5 misaligned group clears", status[2], 0);
    for (int i = 0; i < 3; i++) send_bit(1'b1);
    send_bit(1'b0);
    check(status[2] == 1'b1, "R5 per-bit search resumes", status[2], 1);
    send_byte(8'h00);
    check(status[2] == 1'b0, "R5 clear after data", status[2], 0);

    // Idle
    for (int i = 0; i < 14; i++) send_bit(1'b1);
    check(status[0] == 1'b0, "R6 idle not yet at 14", status[0], 0);
    send_bit(1'b1);
    check(status[0] == 1'b1, "R6 idle at 15", status[0], 1);
    for (int i = 0; i < 40; i++) send_bit(1'b1);
    check(status[0] == 1'b1, "R8 idle through long run", status[0], 1);

    // R9: strobe low, rx toggling
    snap = status;
    idle_cycles(20);
    check(status == snap, "R9 no change without strobe", status, snap);
    send_bit(1'b0);
    check(status[0] == 1'b0, "R7 single zero clears idle", status[0], 0);

    // R10: carrier delay
    carrier = 1'b1;
    @(negedge clk);
    check(status[1] == 1'b1, "R10 carrier rises one clock later", status[1], 1);
    carrier = 1'b0;
    @(negedge clk);
    check(status[1] == 1'b0, "R10 carrier falls one clock later", status[1], 0);

    // Mixed traffic against the model
    for (int n = 0; n < 3000; n++) begin
      int kind;
      kind = $urandom_range(0, 9);
      carrier = $urandom_range(0, 1);
      if (kind < 3) begin
        send_byte(8'h7E);
      end else if (kind < 4) begin
        for (int i = 0; i < $urandom_range(10, 25); i++) send_bit(1'b1);
      end else if (kind < 6) begin
        idle_cycles($urandom_range(1, 3));
      end else begin
        send_bit($urandom_range(0, 1));
      end
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule